// File: doc/BRIEF.md
# Byte-array programming controller with CPU stall

This block sits between a CPU register bus and a small nonvolatile-style byte array, held here as a synthesizable register array of 2^ADDR_W bytes (2048 by default). Software loads an address register and a data register, then writes a control register. Bit 0 of that control write asks for a read. Bit 1 starts a programming cycle. During a programming cycle the block reports itself busy, and software polls that flag until it reads zero.

A read moves the addressed byte into the data register at the accepting edge and holds the CPU with a stall request for RD_STALL cycles. A programming cycle captures the address and data into shadow registers and holds the CPU for WR_STALL cycles. It then counts PROG_TICKS pulses of a slow-oscillator tick enable that is synchronous to the CPU clock. On the final tick the shadow byte is written into the array and busy drops. While busy, read requests and address-register writes are discarded.

Two state machines carry the behaviour. The stall machine has the states ST_IDLE, ST_RD_HOLD and ST_WR_HOLD. A read start moves it from ST_IDLE to ST_RD_HOLD, and a write start moves it from ST_IDLE to ST_WR_HOLD. Each hold state returns to ST_IDLE when its down-counter expires. The programming machine has the states PG_IDLE and PG_COUNT. It moves from PG_IDLE to PG_COUNT on a write start, and from PG_COUNT back to PG_IDLE on the last counted tick, which is the commit transition.

Top module: `nvbyte_ctrl`

## Requirements
- R1: Synchronous active-high reset clears busy, stall, the address register and the data register to zero.
- R2: A bus write with selector 0 loads the address register from bus bits [ADDR_W-1:0]. Selector 1 loads the data register from bits [7:0]. Selector 2 is the control register, with bit 0 as the read request and bit 1 as the write request. Selector 3 has no effect.
- R3: An accepted read loads the data register with the array byte at the current address on the accepting edge, so the byte is visible in the next cycle.
- R4: An accepted read raises stall for exactly RD_STALL (default 4) consecutive cycles, starting the cycle after the request.
- R5: An accepted write sets busy in the next cycle and raises stall for exactly WR_STALL (default 2) cycles.
- R6: Busy clears on the edge that samples the PROG_TICKS-th asserted osc_tick after the start edge, and the array byte is written on that same edge. A tick present on the start edge is not counted.
- R7: Address-register writes are ignored while busy.
- R8: Read requests are ignored while busy, and the data register keeps its value.
- R9: The programmed byte and location are the ones present at the start edge; later data-register writes do not change them.
- R10: A control write with both bits set starts a write and drops the read.
- R11: Control requests that arrive while stall is high are ignored.
- R12: A request on the commit edge still sees busy, so an address write on that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-cycle programming-oscillator tick enable |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register selector: 0 address, 1 data, 2 control |
| bus_wdata | input | BUS_W | Register write data |
| rd_byte | output | DATA_W | Data register contents |
| addr_q | output | ADDR_W | Address register contents |
| busy | output | 1 | Programming in progress (write-enable readback) |
| stall | output | 1 | CPU stall request |

## Verification
The commit of a programming cycle can land in the same cycle as a new bus request, because the final tick and a CPU access are independent. The bench provokes this by holding an address write exactly on the cycle that carries the last counted tick. It then checks that busy falls, that the address register keeps its old value, and that a later read returns the shadowed byte. The second collision is a control write with both request bits set. It is judged by a two-cycle stall, busy set, and a data register that keeps its own value rather than the array byte.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam int CTRL_RD_BIT = 0;
    localparam int CTRL_WR_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_HOLD = 2'd1,
        ST_WR_HOLD = 2'd2
    } stall_state_t;

    typedef enum logic {
        PG_IDLE  = 1'b0,
        PG_COUNT = 1'b1
    } prog_state_t;
endpackage

// File: rtl/nvc_stall_fsm.sv
module nvc_stall_fsm
    import nvc_pkg::*;
#(
    parameter int RD_CYC = 4,
    parameter int WR_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_rd,
    input  logic start_wr,
    output logic stall,
    output logic idle
);
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);

    stall_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr) begin
                    state_d = ST_WR_HOLD;
                    cnt_d   = WR_LOAD;
                end else if (start_rd) begin
                    state_d = ST_RD_HOLD;
                    cnt_d   = RD_LOAD;
                end
            end
            ST_RD_HOLD, ST_WR_HOLD: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        stall = (state_q != ST_IDLE);
        idle  = (state_q == ST_IDLE);
    end
endmodule

// File: rtl/nvc_prog_fsm.sv
module nvc_prog_fsm
    import nvc_pkg::*;
#(
    parameter int PROG_TICKS = 26368
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic commit
);
    localparam int CW = $clog2(PROG_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PROG_TICKS - 1);

    prog_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          last_tick;

    assign last_tick = tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PG_IDLE: begin
                if (start) begin
                    state_d = PG_COUNT;
                    cnt_d   = '0;
                end
            end
            PG_COUNT: begin
                if (last_tick) begin
                    state_d = PG_IDLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = PG_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        busy   = (state_q == PG_COUNT);
        commit = (state_q == PG_COUNT) && last_tick;
    end
endmodule

// File: rtl/nvc_array.sv
module nvc_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
    import nvc_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int BUS_W      = 16,
    parameter int RD_STALL   = 4,
    parameter int WR_STALL   = 2,
    parameter int PROG_TICKS = 26368
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] addr_q,
    output logic              busy,
    output logic              stall
);
    logic [ADDR_W-1:0] addr_r, sh_addr;
    logic [DATA_W-1:0] data_r, sh_data, arr_rdata;
    logic              ctrl_hit, accept, start_rd, start_wr;
    logic              stall_idle, prog_busy, commit;
    logic              unused_hi;

    assign unused_hi = ^bus_wdata;

    assign ctrl_hit = bus_we && (bus_sel == SEL_CTRL);
    assign accept   = !prog_busy && stall_idle;
    assign start_wr = ctrl_hit && accept && bus_wdata[CTRL_WR_BIT];
    assign start_rd = ctrl_hit && accept && bus_wdata[CTRL_RD_BIT]
                      && !bus_wdata[CTRL_WR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_r <= '0;
        end else if (bus_we && (bus_sel == SEL_ADDR) && !prog_busy) begin
            addr_r <= bus_wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_r <= '0;
        end else if (start_rd) begin
            data_r <= arr_rdata;
        end else if (bus_we && (bus_sel == SEL_DATA)) begin
            data_r <= bus_wdata[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_addr <= '0;
            sh_data <= '0;
        end else if (start_wr) begin
            sh_addr <= addr_r;
            sh_data <= data_r;
        end
    end

    nvc_stall_fsm #(
        .RD_CYC(RD_STALL),
        .WR_CYC(WR_STALL)
    ) stall_i (
        .clk     (clk),
        .rst     (rst),
        .start_rd(start_rd),
        .start_wr(start_wr),
        .stall   (stall),
        .idle    (stall_idle)
    );

    nvc_prog_fsm #(
        .PROG_TICKS(PROG_TICKS)
    ) prog_i (
        .clk   (clk),
        .rst   (rst),
        .start (start_wr),
        .tick  (osc_tick),
        .busy  (prog_busy),
        .commit(commit)
    );

    nvc_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) array_i (
        .clk  (clk),
        .we   (commit),
        .waddr(sh_addr),
        .wdata(sh_data),
        .raddr(addr_r),
        .rdata(arr_rdata)
    );

    assign rd_byte = data_r;
    assign addr_q  = addr_r;
    assign busy    = prog_busy;
endmodule

// File: rtl/nvbyte_ctrl_chk.sv
module nvbyte_ctrl_chk
    import nvc_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int BUS_W    = 16,
    parameter int RD_STALL = 4,
    parameter int WR_STALL = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              osc_tick,
    input logic              bus_we,
    input logic [1:0]        bus_sel,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0] rd_byte,
    input logic [ADDR_W-1:0] addr_q,
    input logic              busy,
    input logic              stall
);
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)        run_len <= '0;
        else if (stall) run_len <= run_len + 16'd1;
        else            run_len <= '0;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !stall && addr_q == '0 && rd_byte == '0));

    assert_stall_length_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> (run_len == 16'(RD_STALL) || run_len == 16'(WR_STALL)));

    assert_busy_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_we && bus_sel == SEL_CTRL && bus_wdata[CTRL_WR_BIT]));

    assert_busy_stalls_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> stall);

    assert_end_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(osc_tick));

    assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q));

    assert_read_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !(bus_we && bus_sel == SEL_DATA)) |=> $stable(rd_byte));
endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BUS_W   (BUS_W),
    .RD_STALL(RD_STALL),
    .WR_STALL(WR_STALL)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .bus_we   (bus_we),
    .bus_sel  (bus_sel),
    .bus_wdata(bus_wdata),
    .rd_byte  (rd_byte),
    .addr_q   (addr_q),
    .busy     (busy),
    .stall    (stall)
);

// File: tb/nvbyte_ctrl_tb_top.sv
module nvbyte_ctrl_tb_top;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int BW = 16;
    localparam int RDS = 4;
    localparam int WRS = 2;
    localparam int PT = 12;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b0;
    logic bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [BW-1:0] bus_wdata = '0;
    logic [DW-1:0] rd_byte;
    logic [AW-1:0] addr_q;
    logic busy, stall;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur = "R1";

    // bench reference state
    logic [AW-1:0] m_addr, m_sa;
    logic [DW-1:0] m_data, m_sd;
    bit m_dval, m_busy;
    int m_stall, m_ticks;
    logic [DW-1:0] m_mem [DEPTH];
    bit m_valid [DEPTH];

    always #4 clk = ~clk;

    nvbyte_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .BUS_W(BW),
        .RD_STALL(RDS), .WR_STALL(WRS), .PROG_TICKS(PT)
    ) dut_i (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .rd_byte(rd_byte),
        .addr_q(addr_q), .busy(busy), .stall(stall)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(cur, "busy", int'(busy), int'(m_busy));
        chk(cur, "stall", int'(stall), int'(m_stall > 0));
        chk(cur, "addr_q", int'(addr_q), int'(m_addr));
        if (m_dval) chk(cur, "rd_byte", int'(rd_byte), int'(m_data));
    endtask

    function automatic void model_reset();
        m_addr = '0; m_data = '0; m_dval = 1; m_busy = 0;
        m_stall = 0; m_ticks = 0; m_sa = '0; m_sd = '0;
    endfunction

    function automatic void model_step(input bit we, input logic [1:0] sel,
                                       input logic [BW-1:0] wd, input bit tk);
        bit ctrl, acc, was_busy;
        ctrl = we && sel == 2'd2;
        acc = !m_busy && m_stall == 0;
        was_busy = m_busy;
        if (m_stall > 0) m_stall--;
        if (m_busy && tk) begin
            if (m_ticks == PT - 1) begin
                m_mem[m_sa] = m_sd; m_valid[m_sa] = 1; m_busy = 0;
            end else m_ticks++;
        end
        if (we && sel == 2'd0 && !was_busy) m_addr = wd[AW-1:0];
        if (ctrl && acc && wd[1]) begin
            m_sa = m_addr; m_sd = m_data; m_busy = 1; m_ticks = 0; m_stall = WRS;
        end else if (ctrl && acc && wd[0]) begin
            m_data = m_mem[m_addr]; m_dval = m_valid[m_addr]; m_stall = RDS;
        end else if (we && sel == 2'd1) begin
            m_data = wd[DW-1:0]; m_dval = 1;
        end
    endfunction

    task automatic cycle(input bit we, input logic [1:0] sel,
                         input logic [BW-1:0] wd, input bit tk);
        @(negedge clk);
        if (!rst) compare_all();
        bus_we = we; bus_sel = sel; bus_wdata = wd; osc_tick = tk;
        if (rst) model_reset();
        else model_step(we, sel, wd, tk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 2'd0, '0, ($urandom % 3) == 0);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && m_busy; i++) cycle(0, 2'd0, '0, ($urandom % 3) == 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_valid[i] = 0; end
        rst = 1'b1;
        cycle(0, 2'd0, '0, 0);
        cycle(0, 2'd0, '0, 0);
        rst = 1'b0;
        cycle(0, 2'd0, '0, 0);
        // R1 reset state
        @(negedge clk);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "addr_q", int'(addr_q), 0);
        chk("R1", "rd_byte", int'(rd_byte), 0);
        @(posedge clk);

        cur = "R2";
        cycle(1, 2'd0, 16'h0005, 0);
        cycle(1, 2'd1, 16'h00A5, 0);
        cycle(1, 2'd3, 16'h07FF, 0);
        idle(1);

        cur = "R5";
        cycle(1, 2'd2, 16'h0002, 1);
        idle(1);
        chk("R5", "busy after start", int'(busy), 1);
        cur = "R7";
        cycle(1, 2'd0, 16'h0009, 0);
        cur = "R8";
        cycle(1, 2'd2, 16'h0001, 0);
        idle(1);
        chk("R8", "rd_byte kept", int'(rd_byte), 8'hA5);
        cur = "R9";
        cycle(1, 2'd1, 16'h003C, 0);
        cur = "R12";
        for (int i = 0; i < 2000 && !(m_busy && m_ticks == PT - 1); i++)
            cycle(0, 2'd0, '0, ($urandom % 3) == 0);
        cycle(1, 2'd0, 16'h0007, 1);
        idle(1);
        chk("R12", "addr after commit-edge write", int'(addr_q), 5);
        chk("R6", "busy after last tick", int'(busy), 0);

        cur = "R3";
        cycle(1, 2'd2, 16'h0001, 0);
        idle(1);
        chk("R3", "read of programmed byte", int'(rd_byte), 8'hA5);
        cur = "R11";
        cycle(1, 2'd0, 16'h0002, 0);
        cycle(1, 2'd2, 16'h0001, 0);
        cur = "R4";
        idle(4);

        cur = "R10";
        cycle(1, 2'd1, 16'h0011, 0);
        cycle(1, 2'd2, 16'h0003, 0);
        idle(1);
        chk("R10", "data kept on dual request", int'(rd_byte), 8'h11);
        chk("R10", "busy on dual request", int'(busy), 1);
        cur = "R6";
        wait_done();
        idle(2);

        cur = "R2";
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] s;
            logic [BW-1:0] w;
            bit we;
            we = ($urandom % 2) == 0;
            s = 2'($urandom % 4);
            w = 16'($urandom);
            if (s == 2'd0) w = 16'($urandom % 16);
            if (s == 2'd2) w = 16'($urandom % 4);
            cycle(we, s, w, ($urandom % 3) == 0);
        end
        cur = "R6";
        wait_done();
        idle(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule